// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines from peripherals and presents them to a processor. Each line can be enabled or disabled. An enabled line is steered to either the normal interrupt output or the fast interrupt output. Software reaches the block through a small word-addressed register bus. Writes take effect at a clock edge. Read data is combinational from the address.

A programmable table of priority slots sets the service order. Each slot names a source and carries a valid flag. A highest-pending register reports the winning source so that a handler can service it without scanning the pending bits. A separate wake output tells the power controller whether an idle processor should resume. A control bit chooses whether any active line wakes the processor or only enabled ones.

The pending state is not latched. It follows the input lines, so a source stops being pending as soon as its peripheral drops its line.

Top module: `lvl_prio_intc`

## Requirements
- R1: After reset the enable mask, steering register, control register and every priority slot read 0, and `irq_o`, `fiq_o` and `wake_o` are 0.
- R2: The enable mask at byte offset 0x04 is read/write. A 1 in bit n enables source n.
- R3: Offset 0x00 reads raw AND mask AND NOT steering. Offset 0x0C reads raw AND mask AND steering. Offset 0x10 reads the raw input lines.
- R4: Priority slot k lives at offset 0x1C + 4*k. Bit 31 is its valid flag and bits 4:0 hold its source number. It reads back with all other bits 0.
- R5: Offset 0x18 reads bit 31 = 1 and bits 30:16 = source number when a winner exists. The winner is the source of the lowest-index valid slot whose source is pending at 0x00. When no slot qualifies, the register reads 0.
- R6: `irq_o` is the OR of the 0x00 register and `fiq_o` is the OR of the 0x0C register. Both are registered, so each follows its register one clock later.
- R7: The control register is at 0x14 and only bit 0 is stored. With bit 0 at 1, `wake_o` is the OR of raw AND mask. With bit 0 at 0, `wake_o` is the OR of raw. Either way `wake_o` is registered with one clock of latency.
- R8: Reads from unmapped offsets return 0. Writes to 0x00, 0x0C, 0x10, 0x18 and to unmapped offsets change nothing.
- R9: The steering register at 0x08 is read/write. A 1 in bit n routes source n to the fast output, and a 0 routes it to the normal output.
- R10: Pending state is level-sensitive. When a source line falls, the source leaves every pending register and the highest-pending register with no software clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level interrupt lines, synchronous to clk |
| bus_addr | input | ADDR_W | Byte offset of the accessed word (bits 1:0 ignored) |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |
| wake_o | output | 1 | Idle wake request, registered |

## Verification
The assertions assume that the source lines and the bus inputs are synchronous to `clk` and hold stable values across each rising edge. They also assume that every input is held at 0 while reset is asserted. The stimulus meets both conditions: it changes every input only on the falling edge and keeps the lines low during reset. Because of this, one-cycle relations such as a valid winner being followed by `irq_o` hold without a synchronizer. Priority slots may legally name any 5-bit number. The stimulus includes a pending source that no valid slot names, which shows that such a source never wins arbitration.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // word indices (byte offset / 4); the slot base position matters for decode
   localparam int W_IRQPEND = 0;
   localparam int W_MASK    = 1;
   localparam int W_STEER   = 2;
   localparam int W_FIQPEND = 3;
   localparam int W_RAW     = 4;
   localparam int W_CTRL    = 5;
   localparam int W_HIGH    = 6;
   localparam int W_SLOT0   = 7;
   localparam int VALID_BIT = 31;
   localparam int ID_LSB    = 16;
   localparam int ID_FIELD  = 15;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
   import intc_pkg::*;
#(
   parameter int NSRC   = 32,
   parameter int NPRIO  = 32,
   parameter int SRC_W  = 5,
   parameter int WIDX_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WIDX_W-1:0] widx,
   input  logic [31:0]       wdata,
   output logic [NSRC-1:0]   mask_q,
   output logic [NSRC-1:0]   steer_q,
   output logic              only_unmasked_q,
   output logic              slot_valid [NPRIO],
   output logic [SRC_W-1:0]  slot_id    [NPRIO]
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q          <= '0;
         steer_q         <= '0;
         only_unmasked_q <= 1'b0;
      end else if (we) begin
         if (widx == WIDX_W'(W_MASK))  mask_q          <= wdata[NSRC-1:0];
         if (widx == WIDX_W'(W_STEER)) steer_q         <= wdata[NSRC-1:0];
         if (widx == WIDX_W'(W_CTRL))  only_unmasked_q <= wdata[0];
      end
   end

   for (genvar k = 0; k < NPRIO; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_valid[k] <= 1'b0;
            slot_id[k]    <= '0;
         end else if (we && widx == WIDX_W'(W_SLOT0 + k)) begin
            slot_valid[k] <= wdata[VALID_BIT];
            slot_id[k]    <= wdata[SRC_W-1:0];
         end
      end
   end
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
   parameter int NSRC  = 32,
   parameter int NPRIO = 32,
   parameter int SRC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  irq_pend,
   input  logic             slot_valid [NPRIO],
   input  logic [SRC_W-1:0] slot_id    [NPRIO],
   output logic             hp_valid,
   output logic [SRC_W-1:0] hp_id
);
   // scan from the last slot down so the lowest qualifying index wins
   always_comb begin
      hp_valid = 1'b0;
      hp_id    = '0;
      for (int k = NPRIO - 1; k >= 0; k--) begin
         if (slot_valid[k] && (int'(slot_id[k]) < NSRC) && irq_pend[slot_id[k]]) begin
            hp_valid = 1'b1;
            hp_id    = slot_id[k];
         end
      end
   end

   AST_HP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      hp_valid |-> irq_pend[hp_id]); // R5
   AST_HP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hp_valid |-> (int'(hp_id) < NSRC)); // R4
endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_any,
   input  logic fiq_any,
   input  logic wake_any,
   output logic irq_o,
   output logic fiq_o,
   output logic wake_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o  <= 1'b0;
         fiq_o  <= 1'b0;
         wake_o <= 1'b0;
      end else begin
         irq_o  <= irq_any;
         fiq_o  <= fiq_any;
         wake_o <= wake_any;
      end
   end
endmodule

// File: rtl/lvl_prio_intc.sv
module lvl_prio_intc
   import intc_pkg::*;
#(
   parameter int NSRC   = 32,
   parameter int NPRIO  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o,
   output logic              fiq_o,
   output logic              wake_o
);
   localparam int SRC_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam int WIDX_W = ADDR_W - 2;
   localparam int SLOT_W = (NPRIO > 1) ? $clog2(NPRIO) : 1;

   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("NSRC must lie in 1..32");
   end
   if (NPRIO < 1) begin : g_bad_nprio
      $error("NPRIO must be at least 1");
   end
   if ((W_SLOT0 + NPRIO) > (1 << WIDX_W)) begin : g_bad_addr
      $error("ADDR_W too small for the priority slots");
   end

   logic [WIDX_W-1:0] widx;
   logic [NSRC-1:0]   mask_q, steer_q, irq_pend, fiq_pend;
   logic              only_unmasked_q, hp_valid, wake_any;
   logic              slot_valid [NPRIO];
   logic [SRC_W-1:0]  slot_id    [NPRIO];
   logic [SRC_W-1:0]  hp_id;
   logic [SLOT_W-1:0] slot_sel;

   assign widx     = bus_addr[ADDR_W-1:2];
   assign irq_pend = src_i & mask_q & ~steer_q;
   assign fiq_pend = src_i & mask_q & steer_q;
   assign wake_any = only_unmasked_q ? |(src_i & mask_q) : |src_i;
   assign slot_sel = SLOT_W'(widx - WIDX_W'(W_SLOT0));

   intc_cfg_regs #(.NSRC(NSRC), .NPRIO(NPRIO), .SRC_W(SRC_W), .WIDX_W(WIDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .widx(widx), .wdata(bus_wdata),
      .mask_q(mask_q), .steer_q(steer_q), .only_unmasked_q(only_unmasked_q),
      .slot_valid(slot_valid), .slot_id(slot_id));

   intc_prio_arb #(.NSRC(NSRC), .NPRIO(NPRIO), .SRC_W(SRC_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .slot_valid(slot_valid),
      .slot_id(slot_id), .hp_valid(hp_valid), .hp_id(hp_id));

   intc_out_stage u_out (
      .clk(clk), .rst_n(rst_n), .irq_any(|irq_pend), .fiq_any(|fiq_pend),
      .wake_any(wake_any), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o));

   always_comb begin
      bus_rdata = '0;
      if (widx == WIDX_W'(W_IRQPEND))      bus_rdata = 32'(irq_pend);
      else if (widx == WIDX_W'(W_MASK))    bus_rdata = 32'(mask_q);
      else if (widx == WIDX_W'(W_STEER))   bus_rdata = 32'(steer_q);
      else if (widx == WIDX_W'(W_FIQPEND)) bus_rdata = 32'(fiq_pend);
      else if (widx == WIDX_W'(W_RAW))     bus_rdata = 32'(src_i);
      else if (widx == WIDX_W'(W_CTRL))    bus_rdata = {31'b0, only_unmasked_q};
      else if (widx == WIDX_W'(W_HIGH))
         bus_rdata = hp_valid ? {1'b1, ID_FIELD'(hp_id), {ID_LSB{1'b0}}} : 32'b0;
      else if (int'(widx) >= W_SLOT0 && int'(widx) < W_SLOT0 + NPRIO)
         bus_rdata = {slot_valid[slot_sel], 31'(slot_id[slot_sel])};
   end

   AST_MASK_CLEARED: assert property (@(posedge clk)
      $rose(rst_n) |-> (mask_q == '0)); // R1
   AST_HP_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      hp_valid |=> irq_o); // R6
   AST_FIQ_NEEDS_STEER: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> $past(|steer_q)); // R9
   AST_NO_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(src_i == '0) |-> !wake_o); // R7
endmodule

// File: tb/sim_lvl_prio_intc.sv
module sim_lvl_prio_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o, fiq_o, wake_o;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   lvl_prio_intc u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o));

   // {src, mask, steer, expected highest-pending word}
   localparam logic [127:0] VEC [6] = '{
      128'h000000F0_FFFFFFFF_00000000_80070000,
      128'h80000001_FFFFFFFF_00000000_80000000,
      128'h80000000_FFFFFFFF_00000000_00000000,
      128'h0000FF00_00000F00_00000800_800A0000,
      128'hFFFFFFFF_00000000_00000000_00000000,
      128'h40000010_40000010_40000000_80040000
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1; d = rdata;
   endtask

   task automatic set_src(input logic [31:0] v);
      @(negedge clk); src = v;
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(8'h04, d); check("R1 mask", d, 32'h0);
      rd(8'h08, d); check("R1 steer", d, 32'h0);
      rd(8'h14, d); check("R1 ctrl", d, 32'h0);
      rd(8'h1C, d); check("R1 slot0", d, 32'h0);
      rd(8'h18, d); check("R1 high", d, 32'h0);
      check("R1 outputs", {29'b0, irq_o, fiq_o, wake_o}, 32'h0);

      // R7 wake from a masked line while ctrl bit 0 is 0
      set_src(32'h1);
      @(negedge clk);
      check("R7 wake any raw", {31'b0, wake_o}, 32'h1);
      check("R6 masked no irq", {31'b0, irq_o}, 32'h0);
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h14, d); check("R7 ctrl only bit0", d, 32'h1);
      check("R7 wake needs enable", {31'b0, wake_o}, 32'h0);
      wr(8'h04, 32'h1);
      rd(8'h04, d); check("R2 mask readback", d, 32'h1);
      check("R7 wake enabled", {31'b0, wake_o}, 32'h1);
      check("R6 irq asserted", {31'b0, irq_o}, 32'h1);

      // R6 and R10: one clock of latency, and the line falling clears everything
      @(negedge clk); src = 32'h0; #1;
      check("R6 irq still high before edge", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      check("R10 irq follows line", {31'b0, irq_o}, 32'h0);
      rd(8'h10, d); check("R10 raw cleared", d, 32'h0);

      // R8 read-only and unmapped offsets
      set_src(32'h5);
      wr(8'h10, 32'h0);
      rd(8'h10, d); check("R8 raw write ignored", d, 32'h5);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, d); check("R8 irq pend write ignored", d, 32'h1);
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, d); check("R8 high write ignored", d, 32'h0);
      wr(8'hA0, 32'hFFFF_FFFF);
      rd(8'hA0, d); check("R8 unmapped read", d, 32'h0);
      rd(8'hFC, d); check("R8 unmapped read top", d, 32'h0);
      rd(8'h04, d); check("R8 unmapped write no effect", d, 32'h1);

      // R4 slot field layout
      wr(8'h28, 32'h7FFF_FFE5);
      rd(8'h28, d); check("R4 slot invalid readback", d, 32'h0000_0005);

      // slot k names source 31-k; slot 0 left invalid
      for (int k = 0; k < 32; k++)
         wr(8'(28 + 4 * k), (k == 0) ? 32'h0 : (32'h8000_0000 | 32'(31 - k)));
      rd(8'h30, d); check("R4 slot5 readback", d, 32'h8000_001A);

      for (int i = 0; i < 6; i++) begin
         logic [31:0] vs, vm, vt, vh, ei, ef;
         {vs, vm, vt, vh} = VEC[i];
         wr(8'h04, vm);
         wr(8'h08, vt);
         set_src(vs);
         ei = vs & vm & ~vt;
         ef = vs & vm & vt;
         @(negedge clk);
         rd(8'h00, d); check("R3 irq pend", d, ei);
         rd(8'h0C, d); check("R3 fiq pend", d, ef);
         rd(8'h10, d); check("R3 raw", d, vs);
         rd(8'h08, d); check("R9 steer readback", d, vt);
         rd(8'h18, d); check("R5 highest", d, vh);
         check("R6 irq out", {31'b0, irq_o}, {31'b0, |ei});
         check("R6 fiq out", {31'b0, fiq_o}, {31'b0, |ef});
      end

      // R5 slot 0 outranks all later slots
      wr(8'h1C, 32'h8000_001F);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h08, 32'h0);
      set_src(32'h8000_0001);
      rd(8'h18, d); check("R5 slot0 wins", d, 32'h801F_0000);
      // R10 line drop removes the winner
      set_src(32'h0000_0001);
      rd(8'h18, d); check("R10 winner drops", d, 32'h8000_0000);
      set_src(32'h0);
      rd(8'h18, d); check("R10 none pending", d, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule